// File: doc/BRIEF.md
# Hall Commutation and Decay Gate Sequencer

This block turns three Hall sensor levels, spaced 120 electrical degrees apart, and a rotation-direction bit into six gate commands for a three-phase MOSFET bridge. Each phase has one high-side and one low-side gate. While the chopper input is in its on phase, the block drives the sector's source (high) and sink (low) devices. While it is in its off phase, it selects one of four current-recirculation patterns from a decay-mode bit and a synchronous-rectification bit.

The block also applies four overrides in a fixed priority: a disable input, a fault-coast input, an active-low brake, and the rejection of illegal Hall codes. All six gate outputs are registered. Inside each leg, a turn-off takes effect at the next clock edge. A turn-on waits until that leg has had both gates off for `DEAD_CYC` clock cycles, which keeps the two devices of one leg from conducting at the same time.

Top module: `bldc_gate_sequencer`

## Requirements
- R1: The Hall code on `hall_i` is {H1,H2,H3}, with H1 in bit 2. Gate bit 0 is phase A, bit 1 is B and bit 2 is C. With `dir_i`=1 the codes select (high, low) phases as follows: 101→(A,C), 100→(B,C), 110→(B,A), 010→(C,A), 011→(C,B), 001→(A,B).
- R2: With `dir_i`=0 every legal code selects the same two phases as in R1, with the high and low roles swapped. For example, 101 selects (C,A).
- R3: With `chop_on_i`=1 and no override active, exactly the selected high gate and the selected low gate are on.
- R4: With `chop_on_i`=0 and `slow_decay_i`=0: if `sync_rect_i`=0 all six gates are off; if `sync_rect_i`=1 the low gate of the selected high phase and the high gate of the selected low phase are on.
- R5: With `chop_on_i`=0 and `slow_decay_i`=1: if `sync_rect_i`=0 only the selected low gate is on; if `sync_rect_i`=1 the low gates of both selected phases are on and no high gate is on.
- R6: `brake_n_i`=0 turns all three low gates on and all high gates off, whatever the Hall code.
- R7: `disable_i`=1 turns all six gates off and takes priority over every other input, including brake and coast.
- R8: `coast_i`=1 turns all six gates off and takes priority over brake and over normal drive.
- R9: Hall codes 000 and 111 turn all six gates off unless brake is active.
- R10: A gate that is no longer requested turns off at the next clock edge. A turn-on in a leg happens only after both of that leg's gates have been off for `DEAD_CYC` cycles. If the request is steady, it happens exactly `DEAD_CYC` edges after the turn-off edge.
- R11: The high gate and the low gate of one leg are never on in the same cycle.
- R12: While `rst_n` is low at a clock edge, all gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_i | input | 3 | Hall levels {H1,H2,H3} |
| dir_i | input | 1 | Rotation direction |
| chop_on_i | input | 1 | 1 = drive phase, 0 = recirculation phase |
| slow_decay_i | input | 1 | 1 = slow decay, 0 = fast decay |
| sync_rect_i | input | 1 | 1 = synchronous rectification on |
| brake_n_i | input | 1 | Active-low dynamic brake |
| disable_i | input | 1 | Forces all gates off, highest priority |
| coast_i | input | 1 | Fault coast, all gates off |
| gate_hi_o | output | 3 | High-side gate commands, bit 0 = A |
| gate_lo_o | output | 3 | Low-side gate commands, bit 0 = A |

## Verification
The two overrides that can fall in the same cycle are brake and disable; coast can also coincide with brake. The bench asserts brake together with disable, and brake together with coast, while the bridge is driving. It judges the result by requiring all six gates to be off afterwards. The second collision is between a commutation or chop change and a pending dead time. The bench times the recirculation turn-on edge by edge after the turn-off, and it counts any cycle in which one leg shows both gates on.

// File: rtl/bldc_gate_pkg.sv
// Package: shared types for the gate sequencer.
// Assumes three bridge legs; bit 0 = phase A, bit 1 = B, bit 2 = C.
package bldc_gate_pkg;

    localparam int unsigned NUM_LEGS = 3;

    typedef logic [NUM_LEGS-1:0] leg_vec_t;

    typedef struct packed {
        leg_vec_t hi;
        leg_vec_t lo;
    } gate_set_t;

    typedef enum logic [1:0] {
        OFF_ALL_OPEN   = 2'd0,
        OFF_COMPLEMENT = 2'd1,
        OFF_LOW_HOLD   = 2'd2,
        OFF_LOW_PAIR   = 2'd3
    } off_style_t;

    // Map decay mode and rectification bits to a recirculation style.
    function automatic off_style_t pick_off_style(input logic slow, input logic sync_rect);
        off_style_t s;
        case ({slow, sync_rect})
            2'b00:   s = OFF_ALL_OPEN;
            2'b01:   s = OFF_COMPLEMENT;
            2'b10:   s = OFF_LOW_HOLD;
            default: s = OFF_LOW_PAIR;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hall_sector_decode.sv
// Module: hall_sector_decode
// Decodes a 120-degree Hall code and direction into one-hot high and low
// phase selects. Assumes hall = {H1,H2,H3}. Codes 000/111 clear valid.
module hall_sector_decode
    import bldc_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic       dir,
    output logic       valid,
    output leg_vec_t   hi_sel,
    output leg_vec_t   lo_sel
);

    leg_vec_t fwd_hi;
    leg_vec_t fwd_lo;

    // Forward-direction sector table.
    always_comb begin
        valid  = 1'b1;
        fwd_hi = '0;
        fwd_lo = '0;
        case (hall)
            3'b101: begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
            3'b100: begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
            3'b110: begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
            3'b010: begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
            3'b011: begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
            3'b001: begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
            default: valid = 1'b0;
        endcase
    end

    // Reverse direction swaps the source and sink roles.
    always_comb begin
        hi_sel = dir ? fwd_hi : fwd_lo;
        lo_sel = dir ? fwd_lo : fwd_hi;
    end

    AST_SECTOR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones(hi_sel) == 1 && $countones(lo_sel) == 1 && (hi_sel & lo_sel) == '0)); // R1

endmodule

// File: rtl/gate_pattern_select.sv
// Module: gate_pattern_select
// Chooses the requested gate set from the sector, chop phase, decay style
// and the override inputs. Priority: disable, coast, brake, illegal Hall.
// Purely combinational; dead time is applied downstream.
module gate_pattern_select
    import bldc_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  leg_vec_t  hi_sel,
    input  leg_vec_t  lo_sel,
    input  logic      chop_on,
    input  logic      slow_decay,
    input  logic      sync_rect,
    input  logic      brake_n,
    input  logic      disable_drv,
    input  logic      coast,
    output gate_set_t request
);

    off_style_t style;

    // Decay style for the recirculation phase.
    always_comb style = pick_off_style(slow_decay, sync_rect);

    // Priority chain producing the requested gate set.
    always_comb begin
        request = '0;
        if (disable_drv || coast) begin
            request = '0;
        end else if (!brake_n) begin
            request.lo = '1;
        end else if (!valid) begin
            request = '0;
        end else if (chop_on) begin
            request.hi = hi_sel;
            request.lo = lo_sel;
        end else begin
            case (style)
                OFF_ALL_OPEN:   request = '0;
                OFF_COMPLEMENT: begin
                    request.hi = lo_sel;
                    request.lo = hi_sel;
                end
                OFF_LOW_HOLD:   request.lo = lo_sel;
                default:        request.lo = lo_sel | hi_sel;
            endcase
        end
    end

    AST_REQ_NO_LEG_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (request.hi & request.lo) == '0); // R11

endmodule

// File: rtl/dead_time_leg.sv
// Module: dead_time_leg
// One bridge leg: turn-offs are immediate, a turn-on waits until the leg
// has had both gates off for DEAD_CYC cycles. Assumes DEAD_CYC >= 1.
module dead_time_leg #(
    parameter int unsigned DEAD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic gate_hi,
    output logic gate_lo
);

    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEAD_CYC);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic          keep_hi;
    logic          keep_lo;
    logic          turn_off;
    logic          ready;
    logic          start_hi;
    logic          start_lo;
    logic [CW-1:0] off_cnt;

    // Decide which gates stay, which drop and which may start.
    always_comb begin
        keep_hi  = gate_hi & req_hi & ~req_lo;
        keep_lo  = gate_lo & req_lo & ~req_hi;
        turn_off = (gate_hi & ~keep_hi) | (gate_lo & ~keep_lo);
        ready    = (off_cnt == CNT_FULL) & ~turn_off;
        start_hi = req_hi & ~req_lo & ~gate_hi & ~gate_lo & ready;
        start_lo = req_lo & ~req_hi & ~gate_hi & ~gate_lo & ready;
    end

    // Gate registers and the cycles-since-turn-off counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            off_cnt <= CNT_FULL;
        end else begin
            gate_hi <= keep_hi | start_hi;
            gate_lo <= keep_lo | start_lo;
            if (turn_off) begin
                off_cnt <= CNT_ONE;
            end else if (off_cnt != CNT_FULL) begin
                off_cnt <= off_cnt + CNT_ONE;
            end
        end
    end

    // Checker: consecutive cycles with the whole leg off, saturating.
    logic [CW-1:0] gap_cnt;
    logic          leg_on;
    always_comb leg_on = gate_hi | gate_lo;

    // Count observed off cycles for the dead-gap assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= CNT_FULL;
        end else if (leg_on) begin
            gap_cnt <= '0;
        end else if (gap_cnt != CNT_FULL) begin
            gap_cnt <= gap_cnt + CNT_ONE;
        end
    end

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R11

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_on && !$past(leg_on)) |-> (gap_cnt == CNT_FULL)); // R10

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(gate_lo)); // R10

    AST_PROMPT_TURN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi && !req_hi) |=> !gate_hi); // R10

endmodule

// File: rtl/bldc_gate_sequencer.sv
// Module: bldc_gate_sequencer (top)
// Hall sector decode, override priority and decay-pattern selection,
// followed by one dead-time leg per phase. Inputs are assumed to be
// synchronous to clk.
module bldc_gate_sequencer
    import bldc_gate_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    input  logic       chop_on_i,
    input  logic       slow_decay_i,
    input  logic       sync_rect_i,
    input  logic       brake_n_i,
    input  logic       disable_i,
    input  logic       coast_i,
    output logic [2:0] gate_hi_o,
    output logic [2:0] gate_lo_o
);

    logic      sector_valid;
    leg_vec_t  hi_sel;
    leg_vec_t  lo_sel;
    gate_set_t request;

    hall_sector_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .hall   (hall_i),
        .dir    (dir_i),
        .valid  (sector_valid),
        .hi_sel (hi_sel),
        .lo_sel (lo_sel)
    );

    gate_pattern_select u_pattern (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (sector_valid),
        .hi_sel      (hi_sel),
        .lo_sel      (lo_sel),
        .chop_on     (chop_on_i),
        .slow_decay  (slow_decay_i),
        .sync_rect   (sync_rect_i),
        .brake_n     (brake_n_i),
        .disable_drv (disable_i),
        .coast       (coast_i),
        .request     (request)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dead_time_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (request.hi[g]),
            .req_lo  (request.lo[g]),
            .gate_hi (gate_hi_o[g]),
            .gate_lo (gate_lo_o[g])
        );
    end

    AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R7

    AST_COAST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        coast_i |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R8

    AST_BRAKE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_n_i |=> (gate_hi_o == 3'b000)); // R6

    AST_ILLEGAL_HALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((hall_i == 3'b000 || hall_i == 3'b111) && brake_n_i)
            |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R9

endmodule

// File: tb/bldc_gate_sequencer_tb.sv
module bldc_gate_sequencer_tb;

    localparam int unsigned DEAD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic       dir = 1'b1;
    logic       chop = 1'b1;
    logic       slow = 1'b0;
    logic       sr = 1'b0;
    logic       brake_n = 1'b1;
    logic       dis = 1'b0;
    logic       coast = 1'b0;
    logic [2:0] ghi;
    logic [2:0] glo;

    int checks = 0;
    int fails = 0;
    int overlap = 0;

    always #5 clk = ~clk;

    bldc_gate_sequencer #(.DEAD_CYC(DEAD)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hall_i       (hall),
        .dir_i        (dir),
        .chop_on_i    (chop),
        .slow_decay_i (slow),
        .sync_rect_i  (sr),
        .brake_n_i    (brake_n),
        .disable_i    (dis),
        .coast_i      (coast),
        .gate_hi_o    (ghi),
        .gate_lo_o    (glo)
    );

    // R11 monitor: count cycles with one leg fully on.
    always @(negedge clk) if (rst_n && ((ghi & glo) != 3'b000)) overlap++;

    task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual {hi,lo}=%b expected %b", req, act, exp);
        end
    endtask

    // Sector phases from the R1 table (forward); R2 swaps roles.
    task automatic sector(input logic [2:0] h, input logic d, output logic [2:0] hs, output logic [2:0] ls);
        logic [2:0] fh, fl;
        case (h)
            3'b101: begin fh = 3'b001; fl = 3'b100; end
            3'b100: begin fh = 3'b010; fl = 3'b100; end
            3'b110: begin fh = 3'b010; fl = 3'b001; end
            3'b010: begin fh = 3'b100; fl = 3'b001; end
            3'b011: begin fh = 3'b100; fl = 3'b010; end
            default: begin fh = 3'b001; fl = 3'b010; end
        endcase
        hs = d ? fh : fl;
        ls = d ? fl : fh;
    endtask

    task automatic settle();
        repeat (DEAD + 4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check({ghi, glo} == 6'b0, "R12", {ghi, glo}, 6'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_dir(input logic d, input string req);
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        chop = 1'b1; dir = d;
        for (int i = 0; i < 6; i++) begin
            logic [2:0] hs, ls;
            hall = codes[i];
            settle();
            sector(codes[i], d, hs, ls);
            check({ghi, glo} == {hs, ls}, req, {ghi, glo}, {hs, ls});
        end
    endtask

    task automatic t_drive_r3();
        logic [2:0] hs, ls;
        hall = 3'b110; dir = 1'b1; chop = 1'b1; slow = 1'b1; sr = 1'b1;
        settle();
        sector(3'b110, 1'b1, hs, ls);
        check({ghi, glo} == {hs, ls}, "R3", {ghi, glo}, {hs, ls});
    endtask

    task automatic t_fast_decay_r4();
        logic [2:0] hs, ls;
        hall = 3'b011; dir = 1'b0; slow = 1'b0;
        sector(3'b011, 1'b0, hs, ls);
        chop = 1'b1; settle();
        chop = 1'b0; sr = 1'b0; settle();
        check({ghi, glo} == 6'b0, "R4", {ghi, glo}, 6'b0);
        sr = 1'b1; settle();
        check({ghi, glo} == {ls, hs}, "R4", {ghi, glo}, {ls, hs});
    endtask

    task automatic t_slow_decay_r5();
        logic [2:0] hs, ls;
        hall = 3'b100; dir = 1'b1; slow = 1'b1;
        sector(3'b100, 1'b1, hs, ls);
        chop = 1'b1; settle();
        chop = 1'b0; sr = 1'b0; settle();
        check({ghi, glo} == {3'b000, ls}, "R5", {ghi, glo}, {3'b000, ls});
        sr = 1'b1; settle();
        check({ghi, glo} == {3'b000, ls | hs}, "R5", {ghi, glo}, {3'b000, ls | hs});
    endtask

    task automatic t_brake_r6();
        chop = 1'b1; hall = 3'b010; settle();
        brake_n = 1'b0; settle();
        check({ghi, glo} == 6'b000111, "R6", {ghi, glo}, 6'b000111);
        hall = 3'b111; settle();
        check({ghi, glo} == 6'b000111, "R6", {ghi, glo}, 6'b000111);
        brake_n = 1'b1; hall = 3'b010;
    endtask

    task automatic t_disable_r7();
        chop = 1'b1; hall = 3'b001; settle();
        dis = 1'b1; brake_n = 1'b0;
        @(negedge clk);
        check({ghi, glo} == 6'b0, "R7", {ghi, glo}, 6'b0);
        settle();
        check({ghi, glo} == 6'b0, "R7", {ghi, glo}, 6'b0);
        coast = 1'b1; settle();
        check({ghi, glo} == 6'b0, "R7", {ghi, glo}, 6'b0);
        dis = 1'b0; coast = 1'b0; brake_n = 1'b1;
    endtask

    task automatic t_coast_r8();
        chop = 1'b1; hall = 3'b101; settle();
        coast = 1'b1; brake_n = 1'b0;
        @(negedge clk);
        check({ghi, glo} == 6'b0, "R8", {ghi, glo}, 6'b0);
        settle();
        check({ghi, glo} == 6'b0, "R8", {ghi, glo}, 6'b0);
        coast = 1'b0; brake_n = 1'b1;
    endtask

    task automatic t_illegal_r9();
        chop = 1'b1; hall = 3'b000; settle();
        check({ghi, glo} == 6'b0, "R9", {ghi, glo}, 6'b0);
        hall = 3'b111; settle();
        check({ghi, glo} == 6'b0, "R9", {ghi, glo}, 6'b0);
    endtask

    task automatic t_dead_time_r10();
        // Sector 101 forward: A high, C low. Fast decay with rectification
        // then wants A low and C high.
        hall = 3'b101; dir = 1'b1; chop = 1'b1; slow = 1'b0; sr = 1'b1;
        settle();
        chop = 1'b0;
        @(posedge clk); #1;
        check({ghi, glo} == 6'b0, "R10", {ghi, glo}, 6'b0);
        repeat (DEAD - 1) @(posedge clk);
        #1;
        check({ghi, glo} == 6'b0, "R10", {ghi, glo}, 6'b0);
        @(posedge clk); #1;
        check({ghi, glo} == 6'b100_001, "R10", {ghi, glo}, 6'b100_001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_dir(1'b1, "R1");
        t_dir(1'b0, "R2");
        t_drive_r3();
        t_fast_decay_r4();
        t_slow_decay_r5();
        t_brake_r6();
        t_disable_r7();
        t_coast_r8();
        t_illegal_r9();
        t_dead_time_r10();
        check(overlap == 0, "R11", 6'(overlap), 6'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule